// File: doc/BRIEF.md
# Single-Line Slave Bit Engine

This block is the bit-level front end of a slave on a shared, open-drain, single-wire bus with a pull-up. The bus carries no clock. The master frames everything by pulling the line low. The engine synchronises the line into the local clock domain and times each low period from its falling edge. A low that lasts long enough is classified as a bus reset. The engine answers a reset with a presence pulse of its own, timed from the moment the line rises again.

Any other falling edge seen while the engine is idle opens a slot. The `rd_mode` and `tx_bit` inputs are captured at that edge. In a write slot the engine samples the line a fixed time after the edge and reports the level through a one-cycle strobe. In a read slot the engine either holds the line low for a fixed time to send a 0, or leaves it alone to send a 1.

Every time constant is given in microseconds and converted to clock cycles using a cycles-per-microsecond parameter. The output `pull_dn` is the enable of an external open-drain driver: 1 means pull the line low.

Top module: `swb_bit_engine`

## Requirements
- R1: After reset, `pull_dn` and `rx_valid` are 0 and the line is left released.
- R2: A low that lasts RST_US (480 µs) is a bus reset and drops any drive. PRES_WAIT_US (30 µs) after the line next rises, `pull_dn` goes to 1. This delay is counted through the two-stage synchroniser, with up to a few cycles of slack.
- R3: The presence pulse keeps `pull_dn` at 1 for exactly PRES_LOW_US × CLK_PER_US cycles (120 µs) and then releases it.
- R4: A falling edge seen while idle with `rd_mode`=0 is a write slot. SAMPLE_US (30 µs) after the edge, the line level is copied to `rx_bit`, and `rx_valid` is 1 for exactly one cycle. This includes a low that later becomes a reset.
- R5: A falling edge seen while idle with `rd_mode`=1 and `tx_bit`=0 is a read-0 slot. `pull_dn` is 1 from the next cycle for exactly HOLD0_US × CLK_PER_US cycles (30 µs).
- R6: A read slot with `tx_bit`=1 never sets `pull_dn` and produces no `rx_valid`.
- R7: `rd_mode` and `tx_bit` take effect only at the falling edge that opens a slot. Changes to them later in the same slot have no effect.
- R8: A low that is longer than a slot but shorter than RST_US (for example 200 µs or 470 µs) gives no presence pulse. The next falling edge opens a normal slot.
- R9: The engine's own presence pulse opens no slot and gives no `rx_valid`, even when `rd_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Raw level of the bus line |
| rd_mode | input | 1 | 1: the next slot is a read slot; 0: the next slot is a write slot |
| tx_bit | input | 1 | Bit to send in the next read slot |
| pull_dn | output | 1 | 1 enables the open-drain pull-down |
| rx_valid | output | 1 | One-cycle strobe for a received bit |
| rx_bit | output | 1 | Received bit, valid with `rx_valid` |

## Verification
Write slots are driven with short lows (a 1) and long lows (a 0). Comparing the strobe value and its delay from the edge tells a correct sample point from an early or late one. Read slots with both transmit values separate a held-low 0 from an untouched 1, and the exact pull-down width is measured. Reset lows at exactly the threshold, lows just under it and lows of medium length separate a true reset (presence delay and width measured) from an ignored long low. Seeded random mixes of slots, including mode and bit flips in the middle of a slot, show that the controls are captured only at the edge.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSLOT  = 3'd1,
    ST_RSLOT  = 3'd2,
    ST_WAITHI = 3'd3,
    ST_RSTLOW = 3'd4,
    ST_PWAIT  = 3'd5,
    ST_PDRIVE = 3'd6
  } swb_state_e;

  // microsecond constant -> clock cycles
  function automatic int unsigned us2cyc(input int unsigned us, input int unsigned cpu);
    return us * cpu;
  endfunction

  // counter width able to hold values up to maxv
  function automatic int unsigned cnt_width(input int unsigned maxv);
    return $clog2(maxv + 2);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swb_sync_edge.sv
module swb_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall_ev,
  output logic rise_ev
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= line_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b1;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= line_s;
  end

  assign line_s  = chain[STAGES-1];
  assign fall_ev = prev & ~line_s;
  assign rise_ev = ~prev & line_s;
endmodule

// File: rtl/swb_timer.sv
module swb_timer #(
  parameter int W = 8,
  parameter int LIMIT = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(1);
    else if (load)       cnt <= W'(1);
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swb_bit_engine.sv
module swb_bit_engine
  import swb_pkg::*;
#(
  parameter int CLK_PER_US   = 50,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_US       = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LOW_US  = 120,
  parameter int SAMPLE_US    = 30,
  parameter int HOLD0_US     = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic rd_mode,
  input  logic tx_bit,
  output logic pull_dn,
  output logic rx_valid,
  output logic rx_bit
);
  localparam int RST_CYC  = us2cyc(RST_US, CLK_PER_US);
  localparam int PW_CYC   = us2cyc(PRES_WAIT_US, CLK_PER_US);
  localparam int PL_CYC   = us2cyc(PRES_LOW_US, CLK_PER_US);
  localparam int SAMP_CYC = us2cyc(SAMPLE_US, CLK_PER_US);
  localparam int HOLD_CYC = us2cyc(HOLD0_US, CLK_PER_US);
  localparam int PH_MAX   = max2(max2(PW_CYC, PL_CYC), max2(SAMP_CYC, HOLD_CYC)) + 1;
  localparam int LT_W     = cnt_width(RST_CYC);
  localparam int PH_W     = cnt_width(PH_MAX);

  logic            line_s, fall_ev, rise_ev;
  logic [LT_W-1:0] low_cnt;
  logic [PH_W-1:0] ph_cnt;
  logic            ph_restart;
  swb_state_e      st;

  // named internal events
  logic bus_reset, samp_pt, hold_end, pwait_end, plow_end;

  swb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .line_s(line_s), .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  // length of the current low period
  swb_timer #(.W(LT_W), .LIMIT(RST_CYC)) u_low (
    .clk(clk), .rst_n(rst_n), .load(line_s), .cnt(low_cnt)
  );

  // time since the last slot or presence milestone
  swb_timer #(.W(PH_W), .LIMIT(PH_MAX)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_restart), .cnt(ph_cnt)
  );

  assign bus_reset = !line_s && (low_cnt == LT_W'(RST_CYC));
  assign samp_pt   = (st == ST_WSLOT)  && (ph_cnt == PH_W'(SAMP_CYC));
  assign hold_end  = (st == ST_RSLOT)  && (ph_cnt == PH_W'(HOLD_CYC));
  assign pwait_end = (st == ST_PWAIT)  && (ph_cnt == PH_W'(PW_CYC));
  assign plow_end  = (st == ST_PDRIVE) && (ph_cnt == PH_W'(PL_CYC));

  assign ph_restart = ((st == ST_IDLE) && fall_ev)
                    || ((st == ST_RSTLOW) && rise_ev)
                    || pwait_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pull_dn  <= 1'b0;
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (bus_reset) begin
        st      <= ST_RSTLOW;
        pull_dn <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: if (fall_ev) begin
            if (rd_mode) begin
              st      <= ST_RSLOT;
              pull_dn <= !tx_bit;
            end else begin
              st <= ST_WSLOT;
            end
          end
          ST_WSLOT: if (samp_pt) begin
            rx_valid <= 1'b1;
            rx_bit   <= line_s;
            st       <= ST_WAITHI;
          end
          ST_RSLOT: if (hold_end) begin
            pull_dn <= 1'b0;
            st      <= ST_WAITHI;
          end
          ST_WAITHI: if (line_s) st <= ST_IDLE;
          ST_RSTLOW: if (rise_ev) st <= ST_PWAIT;
          ST_PWAIT: if (pwait_end) begin
            pull_dn <= 1'b1;
            st      <= ST_PDRIVE;
          end
          ST_PDRIVE: if (plow_end) begin
            pull_dn <= 1'b0;
            st      <= ST_WAITHI;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/swb_chk.sv
module swb_chk
  import swb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rd_mode,
  input logic       tx_bit,
  input logic       pull_dn,
  input logic       rx_valid,
  input swb_state_e st,
  input logic       fall_ev,
  input logic       bus_reset
);
  // R4
  rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4
  rx_from_wslot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(st == ST_WSLOT));

  // R2
  reset_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!pull_dn && st == ST_RSTLOW));

  // R5
  drive_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_dn) |-> ($past(st == ST_IDLE && fall_ev && rd_mode && !tx_bit)
                        || $past(st == ST_PWAIT)));

  // R9
  pres_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PWAIT || st == ST_PDRIVE) |-> !rx_valid);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !pull_dn);
endmodule

bind swb_bit_engine swb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .tx_bit(tx_bit),
  .pull_dn(pull_dn), .rx_valid(rx_valid), .st(st),
  .fall_ev(fall_ev), .bus_reset(bus_reset)
);

// File: tb/sim_swb_bit_engine.sv
module sim_swb_bit_engine;
  localparam int CPU     = 4;
  localparam int RST_US  = 480;
  localparam int PW_US   = 30;
  localparam int PL_US   = 120;
  localparam int SAMP_US = 30;
  localparam int HOLD_US = 30;

  logic clk = 1'b0, rst_n = 1'b0, m_low = 1'b0, rd_mode = 1'b0, tx_bit = 1'b1;
  logic pull_dn, rx_valid, rx_bit;
  wire  line = ~(m_low | pull_dn);

  int total = 0, bad = 0, cyc = 0;
  int n_rise = 0, pd_rise = 0, pd_width = 0, n_rx = 0, rx_cyc = 0;
  logic rx_last = 1'b0, pd_q = 1'b0, done = 1'b0;

  swb_bit_engine #(.CLK_PER_US(CPU), .RST_US(RST_US), .PRES_WAIT_US(PW_US),
    .PRES_LOW_US(PL_US), .SAMPLE_US(SAMP_US), .HOLD0_US(HOLD_US)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line), .rd_mode(rd_mode), .tx_bit(tx_bit),
    .pull_dn(pull_dn), .rx_valid(rx_valid), .rx_bit(rx_bit));

  always #10 clk = ~clk;

  function automatic int us2c(input int us);
    return us * CPU;
  endfunction

  // bit the slave should read for a master low of the given length
  function automatic logic exp_bit(input int low_us);
    return (low_us > SAMP_US) ? 1'b0 : 1'b1;
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    pd_q <= pull_dn;
    if (pull_dn && !pd_q) begin n_rise <= n_rise + 1; pd_rise <= cyc; end
    if (!pull_dn && pd_q) pd_width <= cyc - pd_rise;
    if (rx_valid) begin n_rx <= n_rx + 1; rx_last <= rx_bit; rx_cyc <= cyc; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_us(input int us);
    repeat (us2c(us)) @(negedge clk);
  endtask

  task automatic wr_slot(input logic b, input bit flip);
    int rx0, r0, t0, low_us;
    low_us = b ? 6 : 60;
    rd_mode = 1'b0; tx_bit = 1'b1;
    @(negedge clk);
    rx0 = n_rx; r0 = n_rise;
    m_low = 1'b1; t0 = cyc;
    if (flip) begin wait_us(3); rd_mode = 1'b1; tx_bit = 1'b0; wait_us(low_us - 3); end
    else wait_us(low_us);
    m_low = 1'b0;
    wait_us(80 - low_us);
    chk(n_rx - rx0 == 1, "R4 strobe count", n_rx - rx0, 1);
    chk(rx_last == exp_bit(low_us), "R4 bit value", int'(rx_last), int'(exp_bit(low_us)));
    chk(rx_cyc - t0 >= us2c(SAMP_US) && rx_cyc - t0 <= us2c(SAMP_US) + 5,
        "R4 sample delay", rx_cyc - t0, us2c(SAMP_US));
    chk(n_rise == r0, flip ? "R7 no drive after flip" : "R4 no drive", n_rise - r0, 0);
  endtask

  task automatic rd_slot(input logic b, input bit flip);
    int rx0, r0;
    rd_mode = 1'b1; tx_bit = b;
    @(negedge clk);
    rx0 = n_rx; r0 = n_rise;
    m_low = 1'b1;
    wait_us(2);
    m_low = 1'b0;
    if (flip) begin tx_bit = ~b; rd_mode = 1'b0; end
    wait_us(13);
    chk(line == b, b ? "R6 line high" : "R5 line low", int'(line), int'(b));
    wait_us(60);
    if (!b) begin
      chk(n_rise - r0 == 1, flip ? "R7 drive kept" : "R5 drive once", n_rise - r0, 1);
      chk(pd_width == us2c(HOLD_US), "R5 hold width", pd_width, us2c(HOLD_US));
    end else begin
      chk(n_rise == r0, flip ? "R7 no drive after flip" : "R6 no drive", n_rise - r0, 0);
    end
    chk(n_rx == rx0, "R6 no strobe in read", n_rx - rx0, 0);
  endtask

  task automatic bus_rst(input int low_us);
    int rx0, r0, t_rel;
    rd_mode = 1'b1; tx_bit = 1'b1;
    @(negedge clk);
    rx0 = n_rx; r0 = n_rise;
    m_low = 1'b1;
    wait_us(low_us);
    m_low = 1'b0; t_rel = cyc;
    rd_mode = 1'b0;
    wait_us(300);
    chk(n_rise - r0 == 1, "R2 presence seen", n_rise - r0, 1);
    chk(pd_rise - t_rel >= us2c(PW_US) + 1 && pd_rise - t_rel <= us2c(PW_US) + 6,
        "R2 presence delay", pd_rise - t_rel, us2c(PW_US) + 3);
    chk(pd_width == us2c(PL_US), "R3 presence width", pd_width, us2c(PL_US));
    chk(n_rx == rx0, "R9 no strobe from presence", n_rx - rx0, 0);
  endtask

  task automatic long_low(input int low_us, input logic wr);
    int rx0, r0;
    rd_mode = !wr; tx_bit = 1'b1;
    @(negedge clk);
    rx0 = n_rx; r0 = n_rise;
    m_low = 1'b1;
    wait_us(low_us);
    m_low = 1'b0;
    wait_us(300);
    chk(n_rise == r0, "R8 no presence", n_rise - r0, 0);
    chk(n_rx - rx0 == (wr ? 1 : 0), "R8 strobe count", n_rx - rx0, wr ? 1 : 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pull_dn == 1'b0, "R1 pull_dn reset", int'(pull_dn), 0);
    chk(rx_valid == 1'b0, "R1 rx_valid reset", int'(rx_valid), 0);
    chk(line == 1'b1, "R1 line released", int'(line), 1);
    wait_us(10);

    bus_rst(RST_US);
    wr_slot(1'b1, 1'b0);
    wr_slot(1'b0, 1'b0);
    rd_slot(1'b0, 1'b0);
    rd_slot(1'b1, 1'b0);
    wr_slot(1'b1, 1'b1);
    rd_slot(1'b0, 1'b1);
    rd_slot(1'b1, 1'b1);
    long_low(200, 1'b0);
    wr_slot(1'b0, 1'b0);
    long_low(RST_US - 10, 1'b0);
    rd_slot(1'b0, 1'b0);
    long_low(150, 1'b1);
    chk(rx_last == 1'b0, "R8 long write low reads 0", int'(rx_last), 0);
    bus_rst(RST_US + 50);

    for (int i = 0; i < 40; i++) begin
      int kind;
      logic b;
      bit fl;
      kind = $urandom % 8;
      b    = 1'($urandom % 2);
      fl   = ($urandom % 4) == 0;
      if (kind == 0)     bus_rst(RST_US + int'($urandom % 40));
      else if (kind < 4) wr_slot(b, fl);
      else               rd_slot(b, fl);
    end
    finish_run();
  end
endmodule